// File: doc/BRIEF.md
# Four-Bank Selectable Clock Divider

This block turns one high-rate source clock into nine divided clocks grouped in four banks. Bank A has one output, bank B one, bank C two and bank D five. Bank A runs at one half or one quarter of the source rate. Banks B, C and D run at one quarter or one eighth. Each bank has its own ratio select. A separate feedback divider brings the source down by 16 or 32 so that a phase comparator can use it.

All logic runs on one fast clock, `clk_i`, which stands in for the oscillator. When the loop-enable input is high, the dividers advance on every `clk_i` cycle. When it is low, the block is in bypass mode. In bypass mode the dividers advance once per rising edge of a reference clock. That reference is either the crystal clock or the external clock, chosen by a select input. It is synchronised into `clk_i` and edge-detected.

Every divided output comes from one shared down-counter, so all ratios rise together at the divide-by-8 boundary. A new ratio select is taken only at that boundary. An active-low output enable drops the pad drive enable while the dividers keep counting.

Top module: `mbank_clkdiv`

## Requirements
- R1: Every output of a bank carries the same waveform: `qc_o[1]` equals `qc_o[0]`, and all five bits of `qd_o` are equal at all times.
- R2: `qa_o` has a period of 2 source ticks when `sel_a_i` is 0 and 4 ticks when it is 1. It is high for exactly half of each period.
- R3: `qb_o`, `qc_o` and `qd_o` each have a period of 4 source ticks when their own select is 0 and 8 ticks when it is 1. Each is high for exactly half of each period.
- R4: With `pll_en_i` = 1, a source tick is one `clk_i` cycle. With `pll_en_i` = 0, a source tick is one rising edge of the selected reference, and the dividers hold between ticks.
- R5: In bypass mode, `ref_sel_i` = 0 selects `xtal_ref_i` and `ref_sel_i` = 1 selects `ext_ref_i`.
- R6: `fb_o` divides `clk_i` by 32 when `fb_sel_i` is 0 and by 16 when it is 1, with a 50% duty cycle, in both loop and bypass modes.
- R7: `drv_en_o` is 0 while `oe_n_i` is 1 and 1 while it is 0. Disabling the drive does not stop the dividers.
- R8: A synchronous active-high `rst_i` clears every divider. In the first cycle after reset, all bank outputs and `fb_o` are low.
- R9: A bank output at a slower ratio rises only while `qa_o` is high. Whenever two outputs are at the same ratio, they rise in the same cycle.
- R10: A bank's new ratio select is taken only at the divide-by-8 boundary. A change from 8 to 4 therefore leaves no high or low phase shorter than 2 ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | High-rate source clock (oscillator stand-in) |
| rst_i | input | 1 | Synchronous active-high reset |
| pll_en_i | input | 1 | 1: loop mode, source is clk_i; 0: bypass mode, source is the reference |
| ref_sel_i | input | 1 | Reference select: 0 crystal, 1 external |
| xtal_ref_i | input | 1 | Crystal oscillator reference clock |
| ext_ref_i | input | 1 | External reference clock |
| sel_a_i | input | 1 | Bank A ratio: 0 for divide-by-2, 1 for divide-by-4 |
| sel_b_i | input | 1 | Bank B ratio: 0 for divide-by-4, 1 for divide-by-8 |
| sel_c_i | input | 1 | Bank C ratio: 0 for divide-by-4, 1 for divide-by-8 |
| sel_d_i | input | 1 | Bank D ratio: 0 for divide-by-4, 1 for divide-by-8 |
| fb_sel_i | input | 1 | Feedback ratio: 0 for divide-by-32, 1 for divide-by-16 |
| oe_n_i | input | 1 | Active-low output enable |
| qa_o | output | 1 | Bank A clock |
| qb_o | output | 1 | Bank B clock |
| qc_o | output | 2 | Bank C clocks |
| qd_o | output | 5 | Bank D clocks |
| fb_o | output | 1 | Feedback divider output |
| drv_en_o | output | 1 | Pad drive enable for all nine bank outputs |

## Verification
The bench builds the block with its default parameters: two bank C lanes, five bank D lanes and a two-stage reference synchroniser. These settings exercise every lane-equality case and put the bypass edge-detect latency in the path. With the reference clocks at 8 and 12 `clk_i` cycles, the slowest bypass output has a period of 96 cycles. That period is long enough to separate ticks from cycles, and short enough to measure full periods and duty cycles for every ratio pair. Both reference choices and both feedback ratios are reached.

// File: rtl/mbank_clkdiv_pkg.sv
package mbank_clkdiv_pkg;

    // Shared phase counter width: the slowest bank ratio is 2**PH_W.
    localparam int PH_W = 3;
    // Feedback counter width: the slowest feedback ratio is 2**FB_W.
    localparam int FB_W = 5;

    typedef enum logic {
        REF_XTAL = 1'b0,
        REF_EXT  = 1'b1
    } ref_src_e;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
        logic d;
    } bank_sel_t;

    // Pick the slow tap when sel is set, the fast tap otherwise.
    function automatic logic pick_tap(logic [1:0] taps, logic sel);
        return sel ? taps[1] : taps[0];
    endfunction

endpackage

// File: rtl/mbank_tick_gen.sv
module mbank_tick_gen
    import mbank_clkdiv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pll_en_i,
    input  logic ref_sel_i,
    input  logic xtal_ref_i,
    input  logic ext_ref_i,
    output logic tick_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    ref_src_e        src;
    logic            ref_mux;
    logic [SH_W-1:0] sh_q;
    logic            ref_rise;

    assign src     = ref_src_e'(ref_sel_i);
    assign ref_mux = (src == REF_EXT) ? ext_ref_i : xtal_ref_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[SH_W-2:0], ref_mux};
        end
    end

    assign ref_rise = sh_q[SH_W-2] & ~sh_q[SH_W-1];
    assign tick_o   = pll_en_i ? 1'b1 : ref_rise;

endmodule

// File: rtl/mbank_phase_ctr.sv
module mbank_phase_ctr #(
    parameter int W      = 3,
    parameter int OUT_LO = 0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    output logic [W-1:OUT_LO] cnt_o,
    output logic              wrap_o
);
    logic [W-1:0] cnt_q;

    // Down-counter: every bit goes high together on the 0 -> all-ones step.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o  = cnt_q[W-1:OUT_LO];
    assign wrap_o = tick_i && (cnt_q == '0);

    assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_i |=> $stable(cnt_q))
        else $error("counter moved without a source tick");

endmodule

// File: rtl/mbank_bank.sv
module mbank_bank
    import mbank_clkdiv_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             wrap_i,
    input  logic [1:0]       taps_i,
    input  logic             sel_i,
    output logic [LANES-1:0] q_o
);
    logic sel_q;
    logic tap;

    // Ratio changes are taken only at the common alignment point.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sel_q <= 1'b0;
        end else if (wrap_i) begin
            sel_q <= sel_i;
        end
    end

    assign tap = pick_tap(taps_i, sel_q);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign q_o[i] = tap;
    end

    assert_sel_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !wrap_i |=> $stable(sel_q))
        else $error("ratio select taken away from the boundary");

endmodule

// File: rtl/mbank_clkdiv.sv
module mbank_clkdiv
    import mbank_clkdiv_pkg::*;
#(
    parameter int C_LANES     = 2,
    parameter int D_LANES     = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               pll_en_i,
    input  logic               ref_sel_i,
    input  logic               xtal_ref_i,
    input  logic               ext_ref_i,
    input  logic               sel_a_i,
    input  logic               sel_b_i,
    input  logic               sel_c_i,
    input  logic               sel_d_i,
    input  logic               fb_sel_i,
    input  logic               oe_n_i,
    output logic               qa_o,
    output logic               qb_o,
    output logic [C_LANES-1:0] qc_o,
    output logic [D_LANES-1:0] qd_o,
    output logic               fb_o,
    output logic               drv_en_o
);
    localparam int FB_LO = FB_W - 2;

    bank_sel_t           sel;
    logic                tick;
    logic [PH_W-1:0]     ph_cnt;
    logic                ph_wrap;
    logic [FB_W-1:FB_LO] fb_cnt;
    logic                fb_wrap;

    assign sel = '{a: sel_a_i, b: sel_b_i, c: sel_c_i, d: sel_d_i};

    mbank_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk_i, .rst_i, .pll_en_i, .ref_sel_i, .xtal_ref_i, .ext_ref_i,
        .tick_o (tick)
    );

    mbank_phase_ctr #(.W(PH_W), .OUT_LO(0)) u_phase (
        .clk_i, .rst_i,
        .tick_i (tick),
        .cnt_o  (ph_cnt),
        .wrap_o (ph_wrap)
    );

    // Bank A taps bits 0/1 (/2, /4); the other banks tap bits 1/2 (/4, /8).
    mbank_bank #(.LANES(1)) u_bank_a (
        .clk_i, .rst_i, .wrap_i(ph_wrap), .taps_i(ph_cnt[1:0]),
        .sel_i(sel.a), .q_o(qa_o)
    );
    mbank_bank #(.LANES(1)) u_bank_b (
        .clk_i, .rst_i, .wrap_i(ph_wrap), .taps_i(ph_cnt[2:1]),
        .sel_i(sel.b), .q_o(qb_o)
    );
    mbank_bank #(.LANES(C_LANES)) u_bank_c (
        .clk_i, .rst_i, .wrap_i(ph_wrap), .taps_i(ph_cnt[2:1]),
        .sel_i(sel.c), .q_o(qc_o)
    );
    mbank_bank #(.LANES(D_LANES)) u_bank_d (
        .clk_i, .rst_i, .wrap_i(ph_wrap), .taps_i(ph_cnt[2:1]),
        .sel_i(sel.d), .q_o(qd_o)
    );

    // Feedback path always counts the fast clock.
    mbank_phase_ctr #(.W(FB_W), .OUT_LO(FB_LO)) u_fb_ctr (
        .clk_i, .rst_i,
        .tick_i (1'b1),
        .cnt_o  (fb_cnt),
        .wrap_o (fb_wrap)
    );

    // Inverted select: fb_sel_i = 0 picks the slow tap (/32).
    mbank_bank #(.LANES(1)) u_fb (
        .clk_i, .rst_i, .wrap_i(fb_wrap), .taps_i(fb_cnt),
        .sel_i(~fb_sel_i), .q_o(fb_o)
    );

    assign drv_en_o = ~oe_n_i;

    assert_reset_low_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (!qa_o && !qb_o && qc_o == '0 && qd_o == '0 && !fb_o))
        else $error("outputs not low after reset");

    assert_common_rise_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        ($rose(qb_o) || $rose(qc_o[0]) || $rose(qd_o[0])) |-> qa_o)
        else $error("slower bank rose while bank A was low");

endmodule

// File: tb/mbank_clkdiv_tb.sv
module mbank_clkdiv_tb_top;

    localparam int XTAL_P = 8;
    localparam int EXT_P  = 12;

    typedef struct packed {
        logic pll_en;
        logic ref_sel;
        logic sa, sb, sc, sd, fbs;
        logic [7:0] ra, rb, rc, rd, rfb;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd2, 8'd4, 8'd4, 8'd4, 8'd32},
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'd4, 8'd8, 8'd8, 8'd8, 8'd16},
        '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'd4, 8'd4, 8'd8, 8'd4, 8'd32},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'd2, 8'd8, 8'd4, 8'd8, 8'd16},
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'd4, 8'd4, 8'd4, 8'd8, 8'd32}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pll_en = 1'b1, ref_sel = 1'b0, xtal = 1'b0, ext = 1'b0;
    logic sa = 1'b0, sb = 1'b0, sc = 1'b0, sd = 1'b0, fbs = 1'b0, oe_n = 1'b0;
    logic qa, qb, fb, drv_en;
    logic [1:0] qc;
    logic [4:0] qd;

    int checks = 0;
    int errors = 0;
    int xcnt = 0;
    int ecnt = 0;

    always #2 clk = ~clk;

    always @(negedge clk) begin
        xcnt <= (xcnt == XTAL_P/2 - 1) ? 0 : xcnt + 1;
        if (xcnt == XTAL_P/2 - 1) xtal <= ~xtal;
        ecnt <= (ecnt == EXT_P/2 - 1) ? 0 : ecnt + 1;
        if (ecnt == EXT_P/2 - 1) ext <= ~ext;
    end

    mbank_clkdiv dut_i (
        .clk_i(clk), .rst_i(rst), .pll_en_i(pll_en), .ref_sel_i(ref_sel),
        .xtal_ref_i(xtal), .ext_ref_i(ext),
        .sel_a_i(sa), .sel_b_i(sb), .sel_c_i(sc), .sel_d_i(sd),
        .fb_sel_i(fbs), .oe_n_i(oe_n),
        .qa_o(qa), .qb_o(qb), .qc_o(qc), .qd_o(qd), .fb_o(fb), .drv_en_o(drv_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic sig(input int w);
        case (w)
            0: return qa;
            1: return qb;
            2: return qc[0];
            3: return qd[0];
            default: return fb;
        endcase
    endfunction

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Period and high time, in clk cycles, of one output.
    task automatic measure(input int w, output int per, output int hi);
        int g = 0;
        per = 0; hi = 0;
        while (sig(w) !== 1'b0 && g < 4000) begin @(negedge clk); g++; end
        while (sig(w) !== 1'b1 && g < 4000) begin @(negedge clk); g++; end
        while (sig(w) === 1'b1 && g < 4000) begin hi++; @(negedge clk); g++; end
        per = hi;
        while (sig(w) === 1'b0 && g < 4000) begin per++; @(negedge clk); g++; end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int per, hi, tickp, mism, lastq, run, minrun, seen;
        int exp_r [5];
        string names [5];
        names = '{"R2 qa", "R3 qb", "R3 qc", "R3 qd", "R6 fb"};

        // R8: reset clears every divider.
        wait_cycles(4);
        @(negedge clk) rst = 1'b0;
        check(qa == 0 && qb == 0 && qc == 0 && qd == 0 && fb == 0, "R8 outputs low",
              {qa, qb, qc, qd, fb}, 0);
        check(drv_en == 1'b1, "R7 drive on", drv_en, 1);

        // Vector table: R2 R3 R4 R5 R6
        for (int v = 0; v < NV; v++) begin
            pll_en = VECS[v].pll_en; ref_sel = VECS[v].ref_sel;
            sa = VECS[v].sa; sb = VECS[v].sb; sc = VECS[v].sc; sd = VECS[v].sd;
            fbs = VECS[v].fbs;
            wait_cycles(300);
            tickp = VECS[v].pll_en ? 1 : (VECS[v].ref_sel ? EXT_P : XTAL_P);
            exp_r = '{VECS[v].ra * tickp, VECS[v].rb * tickp, VECS[v].rc * tickp,
                      VECS[v].rd * tickp, int'(VECS[v].rfb)};
            for (int w = 0; w < 5; w++) begin
                measure(w, per, hi);
                check(per == exp_r[w], {names[w], " period (R4 R5)"}, per, exp_r[w]);
                check(hi == exp_r[w] / 2, {names[w], " duty"}, hi, exp_r[w] / 2);
            end
        end

        // R1: lanes of a bank are identical.
        pll_en = 1'b1; sa = 1'b1; sb = 1'b0; sc = 1'b1; sd = 1'b0;
        mism = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (qc[1] != qc[0] || !(qd == 5'b00000 || qd == 5'b11111)) mism++;
        end
        check(mism == 0, "R1 lanes equal", mism, 0);

        // R9: with B and D at /4, they rise together; slower rises need qa high.
        mism = 0;
        lastq = {qb, qc[0], qd[0]};
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if ((qb && !lastq[2]) != (qd[0] && !lastq[0])) mism++;
            if (((qb && !lastq[2]) || (qc[0] && !lastq[1])) && !qa) mism++;
            lastq = {qb, qc[0], qd[0]};
        end
        check(mism == 0, "R9 aligned rises", mism, 0);

        // R7: drive disabled, dividers keep running.
        oe_n = 1'b1;
        @(negedge clk);
        check(drv_en == 1'b0, "R7 drive off", drv_en, 0);
        measure(0, per, hi);
        check(per == 4, "R7 qa runs while disabled", per, 4);
        oe_n = 1'b0;
        @(negedge clk);
        check(drv_en == 1'b1, "R7 drive back on", drv_en, 1);

        // R10: switch bank B /8 -> /4 mid-period; no runt phase.
        sb = 1'b1;
        wait_cycles(40);
        measure(1, per, hi);
        wait_cycles(2);
        sb = 1'b0;
        minrun = 100; run = 0; seen = 0; lastq = qb;
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            if (qb == lastq) run++;
            else begin
                if (seen > 0 && run < minrun) minrun = run;
                seen++;
                run = 1;
            end
            lastq = qb;
        end
        check(minrun >= 2, "R10 no runt phase", minrun, 2);
        measure(1, per, hi);
        check(per == 4, "R10 new ratio applied", per, 4);

        // R8: reset mid-run returns everything low.
        @(negedge clk) rst = 1'b1;
        wait_cycles(2);
        @(negedge clk) rst = 1'b0;
        check(qa == 0 && qb == 0 && qc == 0 && qd == 0 && fb == 0, "R8 reset mid-run",
              {qa, qb, qc, qd, fb}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule